// File: doc/BRIEF.md
# Two-Channel DAC Command Interpreter

This block is the register and command layer of a two-channel DAC that is written over I2C. It does not handle the bus wires. A separate I2C byte engine feeds it one event per cycle, marked by a valid strobe: a start condition, an address byte with its read/write bit, a data byte, or a stop condition. The interpreter checks each address byte against the device's own address and against the global address that every device answers. The own address comes from three pins, each strapped to ground, left floating or tied to supply. After a matching write address, the first data byte selects a command and a channel. Each following pair of data bytes forms a 16-bit word, most significant byte first.

Every channel has an input register, an output register and a power-down flag. A command can load the input register, copy the input register to the output register, load both at once while waking the channel, or power the channel down. The `RES_BITS` parameter selects a 16-, 14- or 12-bit variant. The code stored in each register is the top `RES_BITS` bits of the received word.

Top module: `dac_cmd_if`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, every input and output code is zero and both power-down flags are 1 (`pwrDown[0]` is channel A, `pwrDown[1]` is channel B).
- R2: An address event carries `{addr[6:0], rw}` in `evtByte`. It is accepted only when `rw` is 0 and `addr` equals either the global address 0x73 or the own address. The own address is built as follows. Each strap digit is 0 for ground, 1 for floating and 2 for supply (strap code 3 counts as 2). Take v = 9·strapHi + 3·strapMid + strapLo + 4. Then `addr[6:4]` = v[4:2], `addr[3:2]` = `ADDR_MID`, and `addr[1:0]` = v[1:0]. After a rejected address, all data bytes are ignored until the next start.
- R3: Command 0x0 (write input) loads the received code into the input register of the addressed channels only. It leaves the output registers unchanged.
- R4: Command 0x1 (update) copies the input register to the output register of the addressed channels. The copy happens on the edge that accepts the command byte. Any data bytes that follow in the same transfer are ignored.
- R5: Command 0x3 (write and power up) loads the code into both the input register and the output register of the addressed channels. On the same edge it clears their power-down flags.
- R6: Command 0x4 (power down) sets the power-down flag of the addressed channels on the edge that accepts the command byte. Any data bytes that follow are ignored.
- R7: In the command byte, the upper nibble is the command and the lower nibble is the channel. Channel code 0x0 selects A, 0x1 selects B and 0xF selects both. Any other channel code selects neither.
- R8: Command 0xF (no operation) and all other unlisted command codes change no register or flag.
- R9: A word is two data bytes, high byte first. Further byte pairs before a stop are applied as additional words with the same command.
- R10: A stop or a repeated start that arrives after an odd number of data bytes discards the pending half word. A new transfer after a repeated start pairs its bytes afresh.
- R11: The stored code is the received word shifted right by 16 − `RES_BITS`.
- R12: Events are taken only in cycles where `evtValid` is 1. When `evtValid` is 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | An event is present in this cycle |
| evtKind | input | 2 | Event type: 0 start, 1 address, 2 data byte, 3 stop |
| evtByte | input | 8 | Byte belonging to an address or data event |
| strapHi | input | 2 | Most significant address strap: 0 ground, 1 floating, 2 supply |
| strapMid | input | 2 | Middle address strap |
| strapLo | input | 2 | Least significant address strap |
| inCodeA | output | RES_BITS | Input register, channel A |
| inCodeB | output | RES_BITS | Input register, channel B |
| outCodeA | output | RES_BITS | Output register, channel A |
| outCodeB | output | RES_BITS | Output register, channel B |
| pwrDown | output | 2 | Power-down flags, bit 0 channel A, bit 1 channel B |

## Verification
In a write-and-power-up, three things happen on the single edge that completes the word: the input register is loaded, the output register is loaded, and the power-down flag is cleared. The output must take the new word, not the input register's previous value. The bench provokes this with a global-address write-and-power-up to both channels. It first leaves a different value in channel A's input register. It then checks the output code and the cleared flags right after the low byte.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_ADDR  = 2'd1,
    EV_DATA  = 2'd2,
    EV_STOP  = 2'd3
  } evKind_t;

  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] loadIn;
    logic [NUM_CH-1:0] loadOut;
    logic [NUM_CH-1:0] copyOut;
    logic [NUM_CH-1:0] setPd;
    logic [NUM_CH-1:0] clrPd;
  } dacStrobe_t;

  localparam logic [6:0] GLOBAL_ADDR = 7'h73;

  localparam logic [3:0] CMD_WRITE_IN = 4'h0;
  localparam logic [3:0] CMD_UPDATE   = 4'h1;
  localparam logic [3:0] CMD_WRITE_UP = 4'h3;
  localparam logic [3:0] CMD_POWER_DN = 4'h4;

  localparam logic [3:0] CHAN_A   = 4'h0;
  localparam logic [3:0] CHAN_B   = 4'h1;
  localparam logic [3:0] CHAN_ALL = 4'hF;

endpackage

// File: rtl/dac_addr_match.sv
module dac_addr_match
  import dac_cmd_pkg::*;
#(
  parameter logic [1:0] ADDR_MID = 2'b00
) (
  input  logic [1:0] strapHi,
  input  logic [1:0] strapMid,
  input  logic [1:0] strapLo,
  input  logic [6:0] addrIn,
  output logic       addrHit
);

  function automatic logic [4:0] digitOf(input logic [1:0] code);
    return (code == 2'd3) ? 5'd2 : {3'b000, code};
  endfunction

  logic [4:0] packedVal;
  logic [6:0] ownAddr;

  always_comb begin
    packedVal = digitOf(strapHi) * 5'd9 + digitOf(strapMid) * 5'd3
              + digitOf(strapLo) + 5'd4;
    ownAddr   = {packedVal[4:2], ADDR_MID, packedVal[1:0]};
    addrHit   = (addrIn == ownAddr) || (addrIn == GLOBAL_ADDR);
  end

endmodule

// File: rtl/dac_ctl.sv
module dac_ctl
  import dac_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evtValid,
  input  logic [1:0]  evtKind,
  input  logic [7:0]  evtByte,
  input  logic        addrHit,
  output dacStrobe_t  strobe,
  output logic [15:0] word
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_DATA} ctlState_t;

  ctlState_t   state;
  logic [3:0]  cmdReg;
  logic [NUM_CH-1:0] chanMask;
  logic [7:0]  hiByte;
  logic        haveHi;
  evKind_t     kind;

  function automatic logic [NUM_CH-1:0] maskOf(input logic [3:0] chan);
    case (chan)
      CHAN_A:   return 2'b01;
      CHAN_B:   return 2'b10;
      CHAN_ALL: return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction

  assign kind = evKind_t'(evtKind);
  assign word = {hiByte, evtByte};

  always_comb begin
    strobe = '0;
    if (evtValid && kind == EV_DATA) begin
      if (state == ST_CMD) begin
        case (evtByte[7:4])
          CMD_UPDATE:   strobe.copyOut = maskOf(evtByte[3:0]);
          CMD_POWER_DN: strobe.setPd   = maskOf(evtByte[3:0]);
          default: ;
        endcase
      end else if (state == ST_DATA && haveHi) begin
        case (cmdReg)
          CMD_WRITE_IN: strobe.loadIn = chanMask;
          CMD_WRITE_UP: begin
            strobe.loadIn  = chanMask;
            strobe.loadOut = chanMask;
            strobe.clrPd   = chanMask;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmdReg   <= 4'hF;
      chanMask <= '0;
      hiByte   <= '0;
      haveHi   <= 1'b0;
    end else if (evtValid) begin
      case (kind)
        EV_START: begin
          state  <= ST_ADDR;
          haveHi <= 1'b0;
        end
        EV_STOP: begin
          state  <= ST_IDLE;
          haveHi <= 1'b0;
        end
        EV_ADDR: begin
          haveHi <= 1'b0;
          if (state == ST_ADDR && !evtByte[0] && addrHit) state <= ST_CMD;
          else                                             state <= ST_IDLE;
        end
        EV_DATA: begin
          case (state)
            ST_CMD: begin
              cmdReg   <= evtByte[7:4];
              chanMask <= maskOf(evtByte[3:0]);
              haveHi   <= 1'b0;
              state    <= ST_DATA;
            end
            ST_DATA: begin
              if (haveHi) haveHi <= 1'b0;
              else begin
                hiByte <= evtByte;
                haveHi <= 1'b1;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dac_regs.sv
module dac_regs
  import dac_cmd_pkg::*;
#(
  parameter int RES_BITS = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  dacStrobe_t                        strobe,
  input  logic [15:0]                       word,
  output logic [NUM_CH-1:0][RES_BITS-1:0]   inCode,
  output logic [NUM_CH-1:0][RES_BITS-1:0]   outCode,
  output logic [NUM_CH-1:0]                 pwrDown
);

  localparam int SHIFT = 16 - RES_BITS;

  logic [RES_BITS-1:0] code;
  assign code = RES_BITS'(word >> SHIFT);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        inCode[ch]  <= '0;
        outCode[ch] <= '0;
        pwrDown[ch] <= 1'b1;
      end else begin
        if (strobe.loadIn[ch]) inCode[ch] <= code;
        if (strobe.loadOut[ch])      outCode[ch] <= code;
        else if (strobe.copyOut[ch]) outCode[ch] <= inCode[ch];
        if (strobe.setPd[ch])      pwrDown[ch] <= 1'b1;
        else if (strobe.clrPd[ch]) pwrDown[ch] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dac_cmd_if.sv
module dac_cmd_if
  import dac_cmd_pkg::*;
#(
  parameter int         RES_BITS = 16,
  parameter logic [1:0] ADDR_MID = 2'b00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evtValid,
  input  logic [1:0]          evtKind,
  input  logic [7:0]          evtByte,
  input  logic [1:0]          strapHi,
  input  logic [1:0]          strapMid,
  input  logic [1:0]          strapLo,
  output logic [RES_BITS-1:0] inCodeA,
  output logic [RES_BITS-1:0] inCodeB,
  output logic [RES_BITS-1:0] outCodeA,
  output logic [RES_BITS-1:0] outCodeB,
  output logic [1:0]          pwrDown
);

  dacStrobe_t strobe;
  logic [15:0] word;
  logic addrHit;
  logic [NUM_CH-1:0][RES_BITS-1:0] inCode;
  logic [NUM_CH-1:0][RES_BITS-1:0] outCode;

  dac_addr_match #(.ADDR_MID(ADDR_MID)) u_match (
    .strapHi (strapHi),
    .strapMid(strapMid),
    .strapLo (strapLo),
    .addrIn  (evtByte[7:1]),
    .addrHit (addrHit)
  );

  dac_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .evtValid(evtValid),
    .evtKind (evtKind),
    .evtByte (evtByte),
    .addrHit (addrHit),
    .strobe  (strobe),
    .word    (word)
  );

  dac_regs #(.RES_BITS(RES_BITS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .word   (word),
    .inCode (inCode),
    .outCode(outCode),
    .pwrDown(pwrDown)
  );

  assign inCodeA  = inCode[0];
  assign inCodeB  = inCode[1];
  assign outCodeA = outCode[0];
  assign outCodeB = outCode[1];

endmodule

// File: rtl/dac_cmd_if_chk.sv
module dac_cmd_if_chk #(
  parameter int RES_BITS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                evtValid,
  input logic [1:0]          evtKind,
  input logic [RES_BITS-1:0] inCodeA,
  input logic [RES_BITS-1:0] inCodeB,
  input logic [RES_BITS-1:0] outCodeA,
  input logic [RES_BITS-1:0] outCodeB,
  input logic [1:0]          pwrDown
);

  logic dataEvt;
  assign dataEvt = evtValid && (evtKind == 2'd2);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evtValid |=> ($stable(inCodeA) && $stable(inCodeB) && $stable(outCodeA)
                   && $stable(outCodeB) && $stable(pwrDown)));

  // R10
  frame_evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && (evtKind == 2'd0 || evtKind == 2'd3)) |=>
      ($stable(inCodeA) && $stable(inCodeB) && $stable(outCodeA)
       && $stable(outCodeB) && $stable(pwrDown)));

  // R3
  input_reg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dataEvt |=> ($stable(inCodeA) && $stable(inCodeB)));

  // R4
  output_reg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dataEvt |=> ($stable(outCodeA) && $stable(outCodeB)));

  // R6
  pd_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dataEvt |=> !($rose(pwrDown[0]) || $rose(pwrDown[1])));

  // R5
  pd_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dataEvt |=> !($fell(pwrDown[0]) || $fell(pwrDown[1])));

endmodule

bind dac_cmd_if dac_cmd_if_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evtValid(evtValid),
  .evtKind (evtKind),
  .inCodeA (inCodeA),
  .inCodeB (inCodeB),
  .outCodeA(outCodeA),
  .outCodeB(outCodeB),
  .pwrDown (pwrDown)
);

// File: tb/dac_cmd_if_test.sv
`timescale 1ns/1ps
module dac_cmd_if_test;

  localparam logic [1:0] K_START = 2'd0;
  localparam logic [1:0] K_ADDR  = 2'd1;
  localparam logic [1:0] K_DATA  = 2'd2;
  localparam logic [1:0] K_STOP  = 2'd3;

  // vector: {valid, kind, byte, select, expected}
  // select: 0 none, 1 inA, 2 inB, 3 outA, 4 outB, 5 pwrDown
  localparam int NV = 59;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, K_START, 8'h00, 3'd0, 16'h0000},
    {1'b1, K_ADDR,  8'h66, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h12, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h34, 3'd1, 16'h1234},  // R3
    {1'b0, K_DATA,  8'h00, 3'd3, 16'h0000},  // R3
    {1'b1, K_DATA,  8'hAB, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'hCD, 3'd1, 16'hABCD},  // R9
    {1'b1, K_STOP,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_START, 8'h00, 3'd0, 16'h0000},
    {1'b1, K_ADDR,  8'h66, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h10, 3'd3, 16'hABCD},  // R4
    {1'b1, K_DATA,  8'h55, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h66, 3'd1, 16'hABCD},  // R4
    {1'b0, K_DATA,  8'h00, 3'd3, 16'hABCD},  // R4
    {1'b1, K_STOP,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_START, 8'h00, 3'd0, 16'h0000},
    {1'b1, K_ADDR,  8'hE6, 3'd0, 16'h0000},  // R2 global
    {1'b1, K_DATA,  8'h3F, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h0F, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'hF0, 3'd3, 16'h0FF0},  // R5
    {1'b0, K_DATA,  8'h00, 3'd5, 16'h0000},  // R5
    {1'b0, K_DATA,  8'h00, 3'd4, 16'h0FF0},  // R7
    {1'b1, K_STOP,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_START, 8'h00, 3'd0, 16'h0000},
    {1'b1, K_ADDR,  8'h66, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h41, 3'd5, 16'h0002},  // R6
    {1'b1, K_DATA,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h00, 3'd4, 16'h0FF0},  // R6
    {1'b1, K_STOP,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_START, 8'h00, 3'd0, 16'h0000},
    {1'b1, K_ADDR,  8'h68, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h11, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h22, 3'd1, 16'h0FF0},  // R2 wrong address
    {1'b1, K_STOP,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_START, 8'h00, 3'd0, 16'h0000},
    {1'b1, K_ADDR,  8'h67, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h11, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h22, 3'd1, 16'h0FF0},  // R2 read bit
    {1'b1, K_STOP,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_START, 8'h00, 3'd0, 16'h0000},
    {1'b1, K_ADDR,  8'h66, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h05, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h01, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h02, 3'd1, 16'h0FF0},  // R7 reserved channel
    {1'b0, K_DATA,  8'h00, 3'd2, 16'h0FF0},  // R7
    {1'b1, K_STOP,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_START, 8'h00, 3'd0, 16'h0000},
    {1'b1, K_ADDR,  8'h66, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h21, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h09, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'h09, 3'd2, 16'h0FF0},  // R8 reserved command
    {1'b1, K_STOP,  8'h00, 3'd0, 16'h0000},
    {1'b1, K_START, 8'h00, 3'd0, 16'h0000},
    {1'b1, K_ADDR,  8'h66, 3'd0, 16'h0000},
    {1'b1, K_DATA,  8'hFF, 3'd5, 16'h0002},  // R8 no operation
    {1'b1, K_STOP,  8'h00, 3'd0, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evtValid = 1'b0;
  logic [1:0] evtKind = 2'd0;
  logic [7:0] evtByte = 8'h00;
  // straps: floating, ground, supply -> own address 0x33, write byte 0x66
  logic [1:0] strapHi = 2'd1;
  logic [1:0] strapMid = 2'd0;
  logic [1:0] strapLo = 2'd2;

  logic [15:0] inA, inB, outA, outB;
  logic [1:0]  pd;
  logic [11:0] inA12, inB12, outA12, outB12;
  logic [1:0]  pd12;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dac_cmd_if #(.RES_BITS(16)) uut (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtKind(evtKind),
    .evtByte(evtByte), .strapHi(strapHi), .strapMid(strapMid),
    .strapLo(strapLo), .inCodeA(inA), .inCodeB(inB), .outCodeA(outA),
    .outCodeB(outB), .pwrDown(pd)
  );

  dac_cmd_if #(.RES_BITS(12)) uut12 (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtKind(evtKind),
    .evtByte(evtByte), .strapHi(strapHi), .strapMid(strapMid),
    .strapLo(strapLo), .inCodeA(inA12), .inCodeB(inB12), .outCodeA(outA12),
    .outCodeB(outB12), .pwrDown(pd12)
  );

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ev(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    evtValid = 1'b1;
    evtKind  = k;
    evtByte  = b;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  function automatic logic [15:0] pick(input logic [2:0] sel);
    case (sel)
      3'd1:    return inA;
      3'd2:    return inB;
      3'd3:    return outA;
      3'd4:    return outB;
      3'd5:    return {14'd0, pd};
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 values held during reset
    check("R1 inA", inA, 16'h0000);
    check("R1 pwrDown", {14'd0, pd}, 16'h0003);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outB", outB, 16'h0000);
    check("R1 pwrDown 12-bit", {14'd0, pd12}, 16'h0003);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evtValid = VEC[i][29];
      evtKind  = VEC[i][28:27];
      evtByte  = VEC[i][26:19];
      @(negedge clk);
      evtValid = 1'b0;
      if (VEC[i][18:16] != 3'd0)
        check($sformatf("vector %0d", i), pick(VEC[i][18:16]), VEC[i][15:0]);
    end

    // R11 12-bit variant after write-and-power-up of 0x0FF0
    check("R11 outB 12-bit", {4'd0, outB12}, 16'h00FF);

    // R10 stop after odd byte count
    ev(K_START, 8'h00); ev(K_ADDR, 8'h66); ev(K_DATA, 8'h01);
    ev(K_DATA, 8'h77); ev(K_STOP, 8'h00);
    check("R10 stop discards half word", inB, 16'h0FF0);
    // R10 repeated start after odd byte count
    ev(K_START, 8'h00); ev(K_ADDR, 8'h66); ev(K_DATA, 8'h01);
    ev(K_DATA, 8'h88); ev(K_START, 8'h00); ev(K_ADDR, 8'h66);
    ev(K_DATA, 8'h01); ev(K_DATA, 8'h99);
    check("R10 half word pending", inB, 16'h0FF0);
    ev(K_DATA, 8'h11);
    check("R10 repeated start pairs afresh", inB, 16'h9911);
    check("R11 inB 12-bit", {4'd0, inB12}, 16'h0991);
    ev(K_STOP, 8'h00);

    // R12 a byte presented without the valid strobe is not taken
    ev(K_START, 8'h00); ev(K_ADDR, 8'h66); ev(K_DATA, 8'h00);
    ev(K_DATA, 8'h12);
    @(negedge clk);
    evtKind = K_DATA;
    evtByte = 8'h34;
    @(negedge clk);
    check("R12 inA unchanged without valid", inA, 16'h0FF0);
    ev(K_DATA, 8'h56);
    check("R12 word pairs skip invalid cycle", inA, 16'h1256);
    check("R11 inA 12-bit", {4'd0, inA12}, 16'h0125);
    ev(K_STOP, 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule